// File: doc/BRIEF.md
# Double-Buffered Peripheral DMA Descriptor Sequencer

This block holds the buffer descriptors for a peripheral's receive and transmit DMA channels and turns a software "go" into one or two transfer requests to the attached peripheral engine. Each channel keeps a current pointer/count pair and a next pointer/count pair. Software loads the descriptors through a simple register write port, then writes the control register to enable channels. Moving the data over the memory bus is the peripheral's job. This block only hands over descriptors and updates its own state.

A request carries both channels' pointers and lengths and a last flag. It is offered on a valid/ready interface. Once `req_valid` rises, it stays high with a stable payload until the cycle in which `req_ready` is sampled high. After acceptance, the peripheral reports completion with a one-cycle `done_valid` pulse, and `done_ok` says whether it took the work. When a completed request was not last, the next descriptors of the enabled channels are promoted into current, and a second request, always marked last, follows without software help. The enable state is visible on two plain status pins.

Top module: `bdq_unit`

## Requirements
- R1: After reset no request is pending, both status pins are low, and every pointer and counter holds zero. A first request therefore carries zero pointers and lengths.
- R2: Register writes land at these offsets. Receive: current pointer 0x100, current count 0x104, next pointer 0x110, next count 0x114. Transmit: each receive offset plus 8. The control register is at 0x120. Counts take the low 16 bits of the write data. Writes to any other offset change nothing.
- R3: In a control write, bit 0 sets and bit 1 clears the receive enable, and bit 8 sets and bit 9 clears the transmit enable. A clear bit wins over a set bit in the same write. `rx_on` and `tx_on` show the enables.
- R4: A control write made while idle raises a request when, after the write, at least one channel is enabled. The length of a disabled channel is presented as zero. Its pointer is presented unchanged. A control write that leaves both channels disabled raises no request.
- R5: A first request is marked last when any enabled channel has a next count of zero.
- R6: `req_valid` stays high with a stable payload until accepted. It drops in the cycle after acceptance, and no new request is raised before the pending one completes.
- R7: A completion with `done_ok` high zeroes the current count of each channel enabled for that request. Counts of other channels and all pointers are untouched.
- R8: A completion with `done_ok` low changes no register and ends the sequence with no chaining.
- R9: An accepted completion of a non-last request copies next pointer and count into current for each enabled channel, clears its next count, and raises a second request marked last from those values. Completion of the second request zeroes those current counts whatever `done_ok` is, and ends the sequence.
- R10: Descriptor writes made while a request is pending do not alter its payload, and they take effect for later requests. A control write made while busy updates the enables but raises no extra request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register byte offset |
| wr_data | input | PTR_W | Register write data |
| req_valid | output | 1 | Transfer request offered |
| req_ready | input | 1 | Peripheral takes the request |
| req_rx_ptr | output | PTR_W | Receive buffer pointer |
| req_rx_len | output | CNT_W | Receive length (zero when disabled) |
| req_tx_ptr | output | PTR_W | Transmit buffer pointer |
| req_tx_len | output | CNT_W | Transmit length (zero when disabled) |
| req_last | output | 1 | No chained request will follow |
| done_valid | input | 1 | Completion pulse for the accepted request |
| done_ok | input | 1 | Completion status: 1 accepted, 0 refused |
| rx_on | output | 1 | Receive channel enabled |
| tx_on | output | 1 | Transmit channel enabled |

## Verification
The sequencer is driven with four patterns. Transmit only with no next buffer isolates zero-length presentation of the disabled channel. Both channels with an empty transmit next buffer shows that a single empty next count forces last. A refused and then retried transmit chain shows that refusal leaves every descriptor intact. Both channels with loaded next buffers exercise promotion and the final zeroing. Back-pressure on `req_ready`, with descriptor and control writes during that wait, separates the captured payload from the live registers. Re-triggering after each sequence exposes the current and next counts through the next request's lengths.

// File: rtl/bdq_pkg.sv
package bdq_pkg;
  localparam int NCH         = 2;
  localparam int CH_RX       = 0;
  localparam int CH_TX       = 1;
  localparam int CH_STRIDE   = 'h8;
  localparam int OFF_CUR_PTR = 'h100;
  localparam int OFF_CUR_CNT = 'h104;
  localparam int OFF_NXT_PTR = 'h110;
  localparam int OFF_NXT_CNT = 'h114;
  localparam int OFF_CTRL    = 'h120;
  localparam int CTRL_GRP    = 8;   // enable bit at c*8, disable bit at c*8+1

  typedef enum logic [2:0] {
    S_IDLE,
    S_ISSUE1,
    S_WAIT1,
    S_ISSUE2,
    S_WAIT2
  } seq_state_t;
endpackage

// File: rtl/bdq_chan.sv
module bdq_chan #(
  parameter int PTR_W    = 32,
  parameter int CNT_W    = 16,
  parameter int ADDR_W   = 12,
  parameter int A_CURPTR = 'h100,
  parameter int A_CURCNT = 'h104,
  parameter int A_NXTPTR = 'h110,
  parameter int A_NXTCNT = 'h114
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [PTR_W-1:0]  wr_data,
  input  logic              zero_cur,
  input  logic              promote,
  output logic [PTR_W-1:0]  cur_ptr,
  output logic [CNT_W-1:0]  cur_cnt,
  output logic [PTR_W-1:0]  nxt_ptr,
  output logic [CNT_W-1:0]  nxt_cnt
);
  logic hit_cp, hit_cc, hit_np, hit_nc;

  assign hit_cp = wr_en && (wr_addr == ADDR_W'(A_CURPTR));
  assign hit_cc = wr_en && (wr_addr == ADDR_W'(A_CURCNT));
  assign hit_np = wr_en && (wr_addr == ADDR_W'(A_NXTPTR));
  assign hit_nc = wr_en && (wr_addr == ADDR_W'(A_NXTCNT));

  // Completion updates are placed last so they win over a same-cycle write.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_ptr <= '0;
      cur_cnt <= '0;
      nxt_ptr <= '0;
      nxt_cnt <= '0;
    end else begin
      if (hit_cp) cur_ptr <= wr_data;
      if (hit_cc) cur_cnt <= wr_data[CNT_W-1:0];
      if (hit_np) nxt_ptr <= wr_data;
      if (hit_nc) nxt_cnt <= wr_data[CNT_W-1:0];
      if (promote) begin
        cur_ptr <= nxt_ptr;
        cur_cnt <= nxt_cnt;
        nxt_cnt <= '0;
      end else if (zero_cur) begin
        cur_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/bdq_ctrl.sv
module bdq_ctrl
  import bdq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NCH-1:0]    set_bits,
  input  logic [NCH-1:0]    clr_bits,
  output logic              ctrl_wr,
  output logic [NCH-1:0]    en_d,
  output logic [NCH-1:0]    en_q
);
  assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(OFF_CTRL));

  for (genvar c = 0; c < NCH; c++) begin : g_en
    assign en_d[c] = ctrl_wr ? ((en_q[c] | set_bits[c]) & ~clr_bits[c]) : en_q[c];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end
endmodule

// File: rtl/bdq_seq.sv
module bdq_seq
  import bdq_pkg::*;
#(
  parameter int PTR_W = 32,
  parameter int CNT_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ctrl_wr,
  input  logic [NCH-1:0]             en_d,
  input  logic [NCH-1:0][PTR_W-1:0]  cur_ptr,
  input  logic [NCH-1:0][CNT_W-1:0]  cur_cnt,
  input  logic [NCH-1:0][PTR_W-1:0]  nxt_ptr,
  input  logic [NCH-1:0][CNT_W-1:0]  nxt_cnt,
  input  logic                       req_ready,
  input  logic                       done_valid,
  input  logic                       done_ok,
  output logic                       req_valid,
  output logic [NCH-1:0][PTR_W-1:0]  req_ptr,
  output logic [NCH-1:0][CNT_W-1:0]  req_len,
  output logic                       req_last,
  output logic [NCH-1:0]             zero_cur,
  output logic [NCH-1:0]             promote
);
  seq_state_t     state_q;
  logic [NCH-1:0] sel_q;
  logic           last_q;
  logic           launch, first_last, chain, fin_ok;

  always_comb begin
    first_last = 1'b0;
    for (int c = 0; c < NCH; c++)
      if (en_d[c] && (nxt_cnt[c] == '0)) first_last = 1'b1;
  end

  assign launch = (state_q == S_IDLE) && ctrl_wr && (|en_d);
  assign chain  = (state_q == S_WAIT1) && done_valid && done_ok && !last_q;
  assign fin_ok = done_valid && (((state_q == S_WAIT1) && done_ok) || (state_q == S_WAIT2));

  for (genvar c = 0; c < NCH; c++) begin : g_upd
    assign zero_cur[c] = sel_q[c] && fin_ok;
    assign promote[c]  = sel_q[c] && chain;
  end

  assign req_valid = (state_q == S_ISSUE1) || (state_q == S_ISSUE2);
  assign req_last  = last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      sel_q   <= '0;
      last_q  <= 1'b0;
      req_ptr <= '0;
      req_len <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (launch) begin
          sel_q  <= en_d;
          last_q <= first_last;
          for (int c = 0; c < NCH; c++) begin
            req_ptr[c] <= cur_ptr[c];
            req_len[c] <= en_d[c] ? cur_cnt[c] : '0;
          end
          state_q <= S_ISSUE1;
        end
        S_ISSUE1: if (req_ready) state_q <= S_WAIT1;
        S_WAIT1: if (done_valid) begin
          if (chain) begin
            last_q <= 1'b1;
            for (int c = 0; c < NCH; c++) begin
              req_ptr[c] <= sel_q[c] ? nxt_ptr[c] : cur_ptr[c];
              req_len[c] <= sel_q[c] ? nxt_cnt[c] : '0;
            end
            state_q <= S_ISSUE2;
          end else begin
            state_q <= S_IDLE;
          end
        end
        S_ISSUE2: if (req_ready) state_q <= S_WAIT2;
        S_WAIT2:  if (done_valid) state_q <= S_IDLE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bdq_unit.sv
module bdq_unit
  import bdq_pkg::*;
#(
  parameter int PTR_W  = 32,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [PTR_W-1:0]  wr_data,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [PTR_W-1:0]  req_rx_ptr,
  output logic [CNT_W-1:0]  req_rx_len,
  output logic [PTR_W-1:0]  req_tx_ptr,
  output logic [CNT_W-1:0]  req_tx_len,
  output logic              req_last,
  input  logic              done_valid,
  input  logic              done_ok,
  output logic              rx_on,
  output logic              tx_on
);
  logic [NCH-1:0][PTR_W-1:0] cur_ptr, nxt_ptr, req_ptr;
  logic [NCH-1:0][CNT_W-1:0] cur_cnt, nxt_cnt, req_len;
  logic [NCH-1:0]            zero_cur, promote, en_d, en_q, set_bits, clr_bits;
  logic                      ctrl_wr;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign set_bits[c] = wr_data[c*CTRL_GRP];
    assign clr_bits[c] = wr_data[c*CTRL_GRP+1];

    bdq_chan #(
      .PTR_W   (PTR_W),
      .CNT_W   (CNT_W),
      .ADDR_W  (ADDR_W),
      .A_CURPTR(OFF_CUR_PTR + c*CH_STRIDE),
      .A_CURCNT(OFF_CUR_CNT + c*CH_STRIDE),
      .A_NXTPTR(OFF_NXT_PTR + c*CH_STRIDE),
      .A_NXTCNT(OFF_NXT_CNT + c*CH_STRIDE)
    ) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .zero_cur(zero_cur[c]),
      .promote (promote[c]),
      .cur_ptr (cur_ptr[c]),
      .cur_cnt (cur_cnt[c]),
      .nxt_ptr (nxt_ptr[c]),
      .nxt_cnt (nxt_cnt[c])
    );
  end

  bdq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .set_bits(set_bits),
    .clr_bits(clr_bits),
    .ctrl_wr (ctrl_wr),
    .en_d    (en_d),
    .en_q    (en_q)
  );

  bdq_seq #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (ctrl_wr),
    .en_d      (en_d),
    .cur_ptr   (cur_ptr),
    .cur_cnt   (cur_cnt),
    .nxt_ptr   (nxt_ptr),
    .nxt_cnt   (nxt_cnt),
    .req_ready (req_ready),
    .done_valid(done_valid),
    .done_ok   (done_ok),
    .req_valid (req_valid),
    .req_ptr   (req_ptr),
    .req_len   (req_len),
    .req_last  (req_last),
    .zero_cur  (zero_cur),
    .promote   (promote)
  );

  assign req_rx_ptr = req_ptr[CH_RX];
  assign req_rx_len = req_len[CH_RX];
  assign req_tx_ptr = req_ptr[CH_TX];
  assign req_tx_len = req_len[CH_TX];
  assign rx_on      = en_q[CH_RX];
  assign tx_on      = en_q[CH_TX];
endmodule

// File: rtl/bdq_check.sv
module bdq_check #(
  parameter int PTR_W = 32,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [PTR_W-1:0] req_rx_ptr,
  input logic [CNT_W-1:0] req_rx_len,
  input logic [PTR_W-1:0] req_tx_ptr,
  input logic [CNT_W-1:0] req_tx_len,
  input logic             req_last,
  input logic             done_valid,
  input logic             done_ok,
  input logic             rx_on,
  input logic             tx_on
);
  logic pend, lastq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      lastq <= 1'b0;
    end else if (req_valid && req_ready) begin
      pend  <= 1'b1;
      lastq <= req_last;
    end else if (done_valid) begin
      pend  <= 1'b0;
    end
  end

  AST_HOLD_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n) // R6
    req_valid && !req_ready |=> req_valid && $stable(req_tx_ptr) && $stable(req_rx_ptr)
      && $stable(req_tx_len) && $stable(req_rx_len) && $stable(req_last));

  AST_ONE_PENDING: assert property (@(posedge clk) disable iff (!rst_n) // R6
    req_valid |-> !pend);

  AST_TX_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n) // R4
    $rose(req_valid) && !$past(pend) && !tx_on |-> req_tx_len == '0);

  AST_RX_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n) // R4
    $rose(req_valid) && !$past(pend) && !rx_on |-> req_rx_len == '0);

  AST_REFUSE_STOP: assert property (@(posedge clk) disable iff (!rst_n) // R8
    pend && done_valid && !done_ok |=> !req_valid);

  AST_CHAIN_LAST: assert property (@(posedge clk) disable iff (!rst_n) // R9
    pend && done_valid && done_ok && !lastq |=> req_valid && req_last);

  AST_LAST_STOP: assert property (@(posedge clk) disable iff (!rst_n) // R9
    pend && done_valid && lastq |=> !req_valid);
endmodule

bind bdq_unit bdq_check #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_bdq_check (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_rx_ptr(req_rx_ptr),
  .req_rx_len(req_rx_len),
  .req_tx_ptr(req_tx_ptr),
  .req_tx_len(req_tx_len),
  .req_last  (req_last),
  .done_valid(done_valid),
  .done_ok   (done_ok),
  .rx_on     (rx_on),
  .tx_on     (tx_on)
);

// File: tb/bdq_unit_test.sv
module bdq_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        req_ready = 1'b0;
  logic        done_valid = 1'b0;
  logic        done_ok = 1'b0;
  logic        req_valid, req_last, rx_on, tx_on;
  logic [31:0] req_rx_ptr, req_tx_ptr;
  logic [15:0] req_rx_len, req_tx_len;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bdq_unit uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_rx_ptr(req_rx_ptr), .req_rx_len(req_rx_len),
    .req_tx_ptr(req_tx_ptr), .req_tx_len(req_tx_len), .req_last(req_last),
    .done_valid(done_valid), .done_ok(done_ok), .rx_on(rx_on), .tx_on(tx_on)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_req(input string tag, input logic [31:0] rxp, input logic [15:0] rxl,
                            input logic [31:0] txp, input logic [15:0] txl, input logic last);
    check({tag, " valid"}, req_valid, 1);
    check({tag, " rx_ptr"}, req_rx_ptr, rxp);
    check({tag, " rx_len"}, req_rx_len, rxl);
    check({tag, " tx_ptr"}, req_tx_ptr, txp);
    check({tag, " tx_len"}, req_tx_len, txl);
    check({tag, " last"}, req_last, last);
  endtask

  task automatic accept();
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
  endtask

  task automatic complete(input logic ok);
    done_valid = 1'b1; done_ok = ok;
    @(negedge clk);
    done_valid = 1'b0; done_ok = 1'b0;
  endtask

  task automatic t_reset_state();
    check("R1 idle after reset", req_valid, 0);
    check("R1 rx_on reset", rx_on, 0);
    check("R1 tx_on reset", tx_on, 0);
    reg_wr(12'h120, 32'h101);
    expect_req("R1 R5 zero descriptors", 0, 0, 0, 0, 1);
    check("R3 rx_on set", rx_on, 1);
    check("R3 tx_on set", tx_on, 1);
    accept();
    complete(1'b1);
    check("R9 last ends sequence", req_valid, 0);
    reg_wr(12'h120, 32'h202);
    check("R3 rx_on cleared", rx_on, 0);
    check("R3 tx_on cleared", tx_on, 0);
  endtask

  task automatic t_tx_only_backpressure();
    reg_wr(12'h108, 32'h1000);
    reg_wr(12'h10C, 32'h5);
    reg_wr(12'h100, 32'h2000);
    reg_wr(12'h104, 32'h7);
    reg_wr(12'h120, 32'h100);
    expect_req("R2 R4 tx only", 32'h2000, 0, 32'h1000, 5, 1);
    check("R3 tx only rx_on", rx_on, 0);
    check("R3 tx only tx_on", tx_on, 1);
    repeat (3) @(negedge clk);
    check("R6 held valid", req_valid, 1);
    reg_wr(12'h108, 32'h1800);
    check("R10 payload kept", req_tx_ptr, 32'h1000);
    reg_wr(12'h120, 32'h001);
    check("R10 status while busy", rx_on, 1);
    check("R6 still offered", req_valid, 1);
    accept();
    check("R6 drops after accept", req_valid, 0);
    complete(1'b1);
    check("R10 no extra request", req_valid, 0);
    reg_wr(12'h120, 32'h101);
    expect_req("R7 R10 after tx completion", 32'h2000, 7, 32'h1800, 0, 1);
    accept();
    complete(1'b1);
    reg_wr(12'h120, 32'h202);
  endtask

  task automatic t_refuse_then_chain();
    reg_wr(12'h10C, 32'h9);
    reg_wr(12'h118, 32'h3000);
    reg_wr(12'h11C, 32'h4);
    reg_wr(12'h120, 32'h100);
    expect_req("R5 not last", 32'h2000, 0, 32'h1800, 9, 0);
    accept();
    complete(1'b0);
    check("R8 refusal no chain", req_valid, 0);
    reg_wr(12'h120, 32'h100);
    expect_req("R8 nothing changed", 32'h2000, 0, 32'h1800, 9, 0);
    accept();
    complete(1'b1);
    expect_req("R9 chained request", 32'h2000, 0, 32'h3000, 4, 1);
    accept();
    complete(1'b0);
    check("R9 sequence ends", req_valid, 0);
    reg_wr(12'h120, 32'h100);
    expect_req("R9 next cleared and counts zeroed", 32'h2000, 0, 32'h3000, 0, 1);
    accept();
    complete(1'b1);
    reg_wr(12'h120, 32'h200);
  endtask

  task automatic t_both_channels();
    reg_wr(12'h100, 32'h40);
    reg_wr(12'h104, 32'h3);
    reg_wr(12'h110, 32'h80);
    reg_wr(12'h114, 32'h6);
    reg_wr(12'h108, 32'h50);
    reg_wr(12'h10C, 32'h2);
    reg_wr(12'h120, 32'h101);
    expect_req("R2 R5 one empty next", 32'h40, 3, 32'h50, 2, 1);
    accept();
    complete(1'b1);
    check("R5 last single request", req_valid, 0);
    reg_wr(12'h11C, 32'h1);
    reg_wr(12'h120, 32'h101);
    expect_req("R7 both zeroed", 32'h40, 0, 32'h50, 0, 0);
    accept();
    complete(1'b1);
    expect_req("R9 both promoted", 32'h80, 6, 32'h3000, 1, 1);
    accept();
    complete(1'b1);
    check("R9 end after second", req_valid, 0);
  endtask

  task automatic t_ctrl_corners();
    reg_wr(12'h120, 32'h303);
    check("R3 clear wins rx", rx_on, 0);
    check("R3 clear wins tx", tx_on, 0);
    check("R4 no request when disabled", req_valid, 0);
    reg_wr(12'h120, 32'h000);
    check("R4 empty control write", req_valid, 0);
    reg_wr(12'h124, 32'h101);
    check("R2 unmapped offset no request", req_valid, 0);
    check("R2 unmapped offset rx_on", rx_on, 0);
    check("R2 unmapped offset tx_on", tx_on, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_tx_only_backpressure();
    t_refuse_then_chain();
    t_both_channels();
    t_ctrl_corners();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule